// File: doc/BRIEF.md
# Instruction Fetch and Decode Sequencer

This block is the front half of the control unit of a simple accumulator machine. A 4-bit step counter is decoded into sixteen timing lines, and only one of them is high at any moment. During the first three steps the block drives the shared-bus source select together with the register load, increment and memory-read strobes. These strobes take one instruction word from memory into the instruction register, advance the program counter, and split the word into an indirect flag, eight one-hot opcode lines and a 12-bit address. At step 3 the block reports which kind of execution follows: register-reference, I/O, or memory-reference. For an indirect memory-reference instruction it also replaces the address register with the pointer word read from memory.

The execution units downstream take over from step 3 onward. They pulse `exec_done` when an instruction has finished, and the counter returns to step 0 on the next clock. Memory is outside the block. It sees the address register on `mem_addr` and must return the addressed word on `mem_rdata` combinationally. Reset loads the program counter from `start_addr`. A halt request freezes the block until the next reset.

The control state machine has six states:
- `S_FETCH_ADDR` (step 0)
- `S_FETCH_WORD` (step 1)
- `S_DECODE` (step 2)
- `S_DISPATCH` (step 3)
- `S_EXECUTE` (steps 4 to 15)
- `S_HALTED`

Its transitions are:
- Fetch-address goes to fetch-word, fetch-word to decode, decode to dispatch, and dispatch to execute.
- Execute stays in execute until step 15, then wraps to fetch-address.
- Any running state goes to fetch-address on `exec_done`.
- Any running state goes to halted on `halt`.
- Halted stays halted until reset.

Top module: `fetch_sequencer`

## Requirements
- R1: After reset the timing lines read 0x0001 (step 0), the program counter equals `start_addr`, and the address register, instruction register, indirect flag and opcode lines are all zero.
- R2: While running, exactly one timing line is high, `timing[n]` is high at step n, and the step advances by one per clock, wrapping from step 15 to step 0.
- R3: At step 0 the block drives `bus_sel` = 2 (program counter source) and `ar_ld`, and after that clock the address register equals the program counter.
- R4: At step 1 the block drives `bus_sel` = 7 (memory source), `mem_rd`, `ir_ld` and `pc_inc` with `mem_addr` equal to the address register. After that clock the instruction register holds the word read, and the program counter has advanced by one modulo 4096.
- R5: At step 2 the block drives `bus_sel` = 5 (instruction register source) and `ar_ld`. After that clock:
  - the address register holds instruction bits 11..0;
  - `ind_flag` holds bit 15;
  - `op_lines` equals 1 shifted left by bits 14..12.
- R6: At step 3 exactly one class output is high: `cls_reg` when `op_lines[7]` = 1 and `ind_flag` = 0, `cls_io` when `op_lines[7]` = 1 and `ind_flag` = 1, and `cls_mem` when `op_lines[7]` = 0. No class output is high at any other step.
- R7: At step 3 of a memory-reference instruction with `ind_flag` = 1, the block drives `bus_sel` = 7, `mem_rd` and `ar_ld`, and the address register then takes bits 11..0 of the word read. With `ind_flag` = 0 all strobes stay low and the address register holds its value.
- R8: From steps 4 to 15 all strobes stay low. `exec_done` at any running step returns the timing lines to step 0 on the next clock, and the actions of the current step still take place.
- R9: Once `halt` is sampled high, all of the following hold until reset:
  - the timing lines stop changing;
  - all strobes and class outputs stay low;
  - the program counter, address register and instruction register stay unchanged;
  - `exec_done` has no effect.

  This applies from the cycle in which `halt` is sampled, and that cycle's step actions are suppressed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_addr | input | 12 | Program counter value loaded at reset |
| halt | input | 1 | Stops the sequencer until reset |
| exec_done | input | 1 | Execution finished; clears the step counter |
| mem_rdata | input | 16 | Memory word at `mem_addr` (combinational read) |
| mem_addr | output | 12 | Memory address, equal to the address register |
| mem_rd | output | 1 | Memory read strobe |
| bus_sel | output | 3 | Bus source select (2 = PC, 5 = IR, 7 = memory, 0 = none) |
| ar_ld | output | 1 | Address register loads from the bus |
| ir_ld | output | 1 | Instruction register loads from the bus |
| pc_inc | output | 1 | Program counter increments |
| timing | output | 16 | One-hot step lines T0..T15 |
| op_lines | output | 8 | One-hot decoded opcode lines D0..D7 |
| ind_flag | output | 1 | Captured indirect bit |
| cls_reg | output | 1 | Register-reference execution selected (step 3) |
| cls_io | output | 1 | I/O execution selected (step 3) |
| cls_mem | output | 1 | Memory-reference execution selected (step 3) |
| pc_q | output | 12 | Program counter |
| ar_q | output | 12 | Address register |
| ir_q | output | 16 | Instruction register |

## Verification
Two internal states can fall out of step: the state machine and the step counter, or a register and its strobes. In either case the error appears on the ports within one clock. A misplaced strobe or bus code is visible in the same cycle as the step it belongs to. A wrong load appears in `pc_q`, `ar_q` or `ir_q` one clock later. A wrong class choice appears on the class outputs at step 3, a single clock after decode. A counter that fails to clear or wrap shows a wrong timing line on the very next cycle.

// File: rtl/fs_pkg.sv
package fs_pkg;

    typedef enum logic [2:0] {
        BUS_NONE = 3'd0,
        BUS_AR   = 3'd1,
        BUS_PC   = 3'd2,
        BUS_DR   = 3'd3,
        BUS_AC   = 3'd4,
        BUS_IR   = 3'd5,
        BUS_TR   = 3'd6,
        BUS_MEM  = 3'd7
    } bus_src_e;

    typedef enum logic [2:0] {
        S_FETCH_ADDR = 3'd0,
        S_FETCH_WORD = 3'd1,
        S_DECODE     = 3'd2,
        S_DISPATCH   = 3'd3,
        S_EXECUTE    = 3'd4,
        S_HALTED     = 3'd5
    } phase_e;

    typedef struct packed {
        bus_src_e bus;
        logic     ar_ld;
        logic     ir_ld;
        logic     pc_inc;
        logic     mem_rd;
        logic     dec_ld;
    } ctl_t;

    localparam ctl_t CTL_IDLE = '{bus: BUS_NONE, ar_ld: 1'b0, ir_ld: 1'b0,
                                  pc_inc: 1'b0, mem_rd: 1'b0, dec_ld: 1'b0};

endpackage

// File: rtl/fs_step_counter.sv
module fs_step_counter #(
    parameter int CNT_W = 4,
    localparam int STEPS = 1 << CNT_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             adv,
    input  logic             clr,
    output logic [STEPS-1:0] step
);

    logic [CNT_W-1:0] count;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count <= '0;
        end else if (clr) begin
            count <= '0;
        end else if (adv) begin
            count <= count + 1'b1;
        end
    end

    for (genvar g = 0; g < STEPS; g++) begin : g_step_dec
        assign step[g] = (count == CNT_W'(g));
    end

    AST_STEP_WRAPS: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && !clr && step[STEPS-1]) |=> step[0]); // R2

    AST_STEP_ADVANCES: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && !clr && step[0]) |=> step[1]); // R2

endmodule

// File: rtl/fs_op_decoder.sv
module fs_op_decoder #(
    parameter int SEL_W = 3,
    localparam int LINES = 1 << SEL_W
) (
    input  logic [SEL_W-1:0] sel,
    output logic [LINES-1:0] lines
);

    for (genvar g = 0; g < LINES; g++) begin : g_line
        assign lines[g] = (sel == SEL_W'(g));
    end

endmodule

// File: rtl/fs_datapath.sv
module fs_datapath
    import fs_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int OPC_W  = 3,
    localparam int WORD_W = ADDR_W + OPC_W + 1,
    localparam int LINES  = 1 << OPC_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] start_addr,
    input  logic [WORD_W-1:0] mem_rdata,
    input  ctl_t              ctl,
    output logic [ADDR_W-1:0] pc,
    output logic [ADDR_W-1:0] ar,
    output logic [WORD_W-1:0] ir,
    output logic              ind,
    output logic [LINES-1:0]  op_lines
);

    logic [WORD_W-1:0] bus_val;
    logic [LINES-1:0]  dec_lines;

    always_comb begin
        unique case (ctl.bus)
            BUS_PC:  bus_val = WORD_W'(pc);
            BUS_AR:  bus_val = WORD_W'(ar);
            BUS_IR:  bus_val = ir;
            BUS_MEM: bus_val = mem_rdata;
            default: bus_val = '0;
        endcase
    end

    fs_op_decoder #(.SEL_W(OPC_W)) u_opdec (
        .sel   (ir[WORD_W-2 -: OPC_W]),
        .lines (dec_lines)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pc       <= start_addr;
            ar       <= '0;
            ir       <= '0;
            ind      <= 1'b0;
            op_lines <= '0;
        end else begin
            if (ctl.ar_ld)  ar <= bus_val[ADDR_W-1:0];
            if (ctl.ir_ld)  ir <= bus_val;
            if (ctl.pc_inc) pc <= pc + 1'b1;
            if (ctl.dec_ld) begin
                ind      <= ir[WORD_W-1];
                op_lines <= dec_lines;
            end
        end
    end

    AST_IR_TAKES_MEM: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl.ir_ld && ctl.mem_rd) |=> (ir == $past(mem_rdata))); // R4

    AST_DECODE_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        ctl.dec_ld |=> ($onehot(op_lines) && ind == $past(ir[WORD_W-1]))); // R5

    AST_OPLINES_AT_MOST_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(op_lines)); // R5

endmodule

// File: rtl/fs_control_fsm.sv
module fs_control_fsm
    import fs_pkg::*;
#(
    parameter int STEPS = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             halt,
    input  logic             exec_done,
    input  logic [STEPS-1:0] step,
    input  logic             d7,
    input  logic             ind,
    output ctl_t             ctl,
    output logic             adv,
    output logic             clr,
    output logic             running,
    output logic             cls_reg,
    output logic             cls_io,
    output logic             cls_mem
);

    phase_e state, nxt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_FETCH_ADDR;
        else        state <= nxt;
    end

    assign running = (state != S_HALTED) && !halt;
    assign adv     = running;
    assign clr     = running && exec_done;

    always_comb begin
        nxt = state;
        if (state == S_HALTED) begin
            nxt = S_HALTED;
        end else if (halt) begin
            nxt = S_HALTED;
        end else if (exec_done) begin
            nxt = S_FETCH_ADDR;
        end else begin
            unique case (state)
                S_FETCH_ADDR: nxt = S_FETCH_WORD;
                S_FETCH_WORD: nxt = S_DECODE;
                S_DECODE:     nxt = S_DISPATCH;
                S_DISPATCH:   nxt = S_EXECUTE;
                S_EXECUTE:    nxt = step[STEPS-1] ? S_FETCH_ADDR : S_EXECUTE;
                default:      nxt = S_HALTED;
            endcase
        end
    end

    always_comb begin
        ctl     = CTL_IDLE;
        cls_reg = 1'b0;
        cls_io  = 1'b0;
        cls_mem = 1'b0;
        if (running) begin
            unique case (state)
                S_FETCH_ADDR: begin
                    ctl.bus   = BUS_PC;
                    ctl.ar_ld = 1'b1;
                end
                S_FETCH_WORD: begin
                    ctl.bus    = BUS_MEM;
                    ctl.mem_rd = 1'b1;
                    ctl.ir_ld  = 1'b1;
                    ctl.pc_inc = 1'b1;
                end
                S_DECODE: begin
                    ctl.bus    = BUS_IR;
                    ctl.ar_ld  = 1'b1;
                    ctl.dec_ld = 1'b1;
                end
                S_DISPATCH: begin
                    cls_reg = d7 && !ind;
                    cls_io  = d7 && ind;
                    cls_mem = !d7;
                    if (!d7 && ind) begin
                        ctl.bus    = BUS_MEM;
                        ctl.mem_rd = 1'b1;
                        ctl.ar_ld  = 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

    AST_PHASE0_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_FETCH_ADDR) |-> step[0]); // R3
    AST_PHASE1_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_FETCH_WORD) |-> step[1]); // R4
    AST_PHASE2_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_DECODE) |-> step[2]); // R5
    AST_PHASE3_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_DISPATCH) |-> step[3]); // R6
    AST_EXEC_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_EXECUTE) |-> !(step[0] || step[1] || step[2] || step[3])); // R8

endmodule

// File: rtl/fetch_sequencer.sv
module fetch_sequencer
    import fs_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int OPC_W  = 3,
    parameter int CNT_W  = 4,
    localparam int WORD_W = ADDR_W + OPC_W + 1,
    localparam int LINES  = 1 << OPC_W,
    localparam int STEPS  = 1 << CNT_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] start_addr,
    input  logic              halt,
    input  logic              exec_done,
    input  logic [WORD_W-1:0] mem_rdata,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_rd,
    output logic [2:0]        bus_sel,
    output logic              ar_ld,
    output logic              ir_ld,
    output logic              pc_inc,
    output logic [STEPS-1:0]  timing,
    output logic [LINES-1:0]  op_lines,
    output logic              ind_flag,
    output logic              cls_reg,
    output logic              cls_io,
    output logic              cls_mem,
    output logic [ADDR_W-1:0] pc_q,
    output logic [ADDR_W-1:0] ar_q,
    output logic [WORD_W-1:0] ir_q
);

    ctl_t ctl;
    logic adv, clr, running;

    fs_step_counter #(.CNT_W(CNT_W)) u_steps (
        .clk   (clk),
        .rst_n (rst_n),
        .adv   (adv),
        .clr   (clr),
        .step  (timing)
    );

    fs_control_fsm #(.STEPS(STEPS)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .halt      (halt),
        .exec_done (exec_done),
        .step      (timing),
        .d7        (op_lines[LINES-1]),
        .ind       (ind_flag),
        .ctl       (ctl),
        .adv       (adv),
        .clr       (clr),
        .running   (running),
        .cls_reg   (cls_reg),
        .cls_io    (cls_io),
        .cls_mem   (cls_mem)
    );

    fs_datapath #(.ADDR_W(ADDR_W), .OPC_W(OPC_W)) u_dp (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_addr (start_addr),
        .mem_rdata  (mem_rdata),
        .ctl        (ctl),
        .pc         (pc_q),
        .ar         (ar_q),
        .ir         (ir_q),
        .ind        (ind_flag),
        .op_lines   (op_lines)
    );

    assign mem_addr = ar_q;
    assign mem_rd   = ctl.mem_rd;
    assign bus_sel  = ctl.bus;
    assign ar_ld    = ctl.ar_ld;
    assign ir_ld    = ctl.ir_ld;
    assign pc_inc   = ctl.pc_inc;

    AST_ONE_STEP_LINE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot(timing)); // R2

    AST_PC_STEPS_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        pc_inc |=> (pc_q == $past(pc_q) + 1'b1)); // R4

    AST_CLASS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({cls_reg, cls_io, cls_mem})); // R6

    AST_CLASS_ONLY_STEP3: assert property (@(posedge clk) disable iff (!rst_n)
        (cls_reg || cls_io || cls_mem) |-> timing[3]); // R6

    AST_DONE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (exec_done && running) |=> timing[0]); // R8

    AST_HALT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!running && !halt) |=> ($stable(pc_q) && $stable(ar_q) && $stable(ir_q)
                                  && $stable(timing))); // R9

    AST_HALT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !running |-> !(ar_ld || ir_ld || pc_inc || mem_rd)); // R9

endmodule

// File: tb/fetch_sequencer_test.sv
`timescale 1ns/1ps
module fetch_sequencer_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] start_addr = 12'h005;
    logic        halt = 1'b0;
    logic        exec_done = 1'b0;
    logic [15:0] mem_rdata;
    logic [11:0] mem_addr;
    logic        mem_rd, ar_ld, ir_ld, pc_inc;
    logic [2:0]  bus_sel;
    logic [15:0] timing;
    logic [7:0]  op_lines;
    logic        ind_flag, cls_reg, cls_io, cls_mem;
    logic [11:0] pc_q, ar_q;
    logic [15:0] ir_q;

    logic [15:0] mem [0:63];
    assign mem_rdata = mem[mem_addr[5:0]];

    always #2 clk = ~clk;

    fetch_sequencer uut (
        .clk(clk), .rst_n(rst_n), .start_addr(start_addr), .halt(halt),
        .exec_done(exec_done), .mem_rdata(mem_rdata), .mem_addr(mem_addr),
        .mem_rd(mem_rd), .bus_sel(bus_sel), .ar_ld(ar_ld), .ir_ld(ir_ld),
        .pc_inc(pc_inc), .timing(timing), .op_lines(op_lines), .ind_flag(ind_flag),
        .cls_reg(cls_reg), .cls_io(cls_io), .cls_mem(cls_mem),
        .pc_q(pc_q), .ar_q(ar_q), .ir_q(ir_q)
    );

    int n_chk = 0;
    int n_bad = 0;

    int          m_step;
    logic [11:0] m_pc, m_ar;
    logic [15:0] m_ir;
    logic        m_ind, m_dec, m_halted;
    logic [2:0]  m_op;

    task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic do_reset(logic [11:0] sa);
        rst_n = 1'b0; halt = 1'b0; exec_done = 1'b0; start_addr = sa;
        repeat (2) @(posedge clk);
        #1 rst_n = 1'b1;
        m_step = 0; m_pc = sa; m_ar = '0; m_ir = '0;
        m_ind = 1'b0; m_dec = 1'b0; m_halted = 1'b0; m_op = '0;
        #1;
        chk("R1", "timing after reset", timing, 32'h1);
        chk("R1", "pc after reset", pc_q, sa);
        chk("R1", "ar/ir after reset", {ar_q, ir_q}, 32'h0);
        chk("R1", "decode after reset", {ind_flag, op_lines}, 32'h0);
    endtask

    task automatic tick(logic d, logic h);
        logic       run, ind_rd;
        logic [2:0] e_bus;
        logic       e_ar, e_ir, e_pc, e_rd, e_reg, e_io, e_mem;
        logic [15:0] rd;
        string      lb;
        exec_done = d; halt = h;
        #1;
        run = !m_halted && !h;
        e_bus = 3'd0; e_ar = 0; e_ir = 0; e_pc = 0; e_rd = 0;
        e_reg = 0; e_io = 0; e_mem = 0;
        ind_rd = 1'b0;
        if (!run)             lb = "R9";
        else if (m_step == 0) lb = "R3";
        else if (m_step == 1) lb = "R4";
        else if (m_step == 2) lb = "R5";
        else if (m_step == 3) lb = "R7";
        else                  lb = "R8";
        if (run) begin
            case (m_step)
                0: begin e_bus = 3'd2; e_ar = 1; end
                1: begin e_bus = 3'd7; e_rd = 1; e_ir = 1; e_pc = 1; end
                2: begin e_bus = 3'd5; e_ar = 1; end
                3: begin
                    e_reg = (m_op == 3'd7) && !m_ind;
                    e_io  = (m_op == 3'd7) && m_ind;
                    e_mem = (m_op != 3'd7);
                    if ((m_op != 3'd7) && m_ind) begin
                        e_bus = 3'd7; e_rd = 1; e_ar = 1; ind_rd = 1;
                    end
                end
                default: ;
            endcase
        end
        chk("R2", "timing line", timing, 32'h1 << m_step);
        chk(lb, "bus_sel", bus_sel, e_bus);
        chk(lb, "strobes ar/ir/pc/rd", {ar_ld, ir_ld, pc_inc, mem_rd}, {e_ar, e_ir, e_pc, e_rd});
        chk("R6", "class outputs", {cls_reg, cls_io, cls_mem}, {e_reg, e_io, e_mem});
        chk("R4", "mem_addr follows ar", mem_addr, m_ar);
        chk("R5", "op_lines", op_lines, m_dec ? (32'h1 << m_op) : 32'h0);
        chk("R5", "ind_flag", ind_flag, m_ind);
        chk(lb, "pc/ar/ir", {pc_q, ar_q, ir_q}, {m_pc, m_ar, m_ir});
        rd = mem[m_ar[5:0]];
        if (run) begin
            case (m_step)
                0: m_ar = m_pc;
                1: begin m_ir = rd; m_pc = m_pc + 12'd1; end
                2: begin m_ar = m_ir[11:0]; m_ind = m_ir[15]; m_op = m_ir[14:12]; m_dec = 1'b1; end
                3: if (ind_rd) m_ar = rd[11:0];
                default: ;
            endcase
            m_step = d ? 0 : (m_step + 1) % 16;
        end
        if (h) m_halted = 1'b1;
        @(posedge clk);
        #1;
    endtask

    initial begin
        #(4 * 200000);
        n_bad++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        for (int i = 0; i < 64; i++) mem[i] = 16'(i * 16'h0123 + 16'h0457);
        do_reset(12'h005);

        // Sweep all opcode / indirect combinations: R3 R4 R5 R6 R7 R8
        for (int k = 0; k < 16; k++) begin
            logic [11:0] fld;
            fld = 12'hA00 + 12'(40 + k);
            mem[m_pc[5:0]] = {k[3], k[2:0], fld};
            mem[fld[5:0]]  = 16'hF000 | 16'(12'h300 + 12'(k));
            tick(0, 0); tick(0, 0); tick(0, 0);
            if (k[2:0] == 3'd7) begin
                tick(1, 0);
                chk("R8", "step after done at T3", timing, 32'h1);
            end else begin
                tick(0, 0);
                chk("R7", "ar after T3", ar_q, k[3] ? (12'h300 + 12'(k)) : fld);
                tick(0, 0); tick(1, 0);
                chk("R8", "step after done at T5", timing, 32'h1);
            end
        end

        // Free run through wrap without done: R2
        for (int i = 0; i < 18; i++) tick(0, 0);
        chk("R2", "step after 18 cycles", timing, 32'h1 << 2);

        // Done at step 1 still loads IR, then clears: R8
        while (m_step != 0) tick(0, 0);
        tick(0, 0);
        tick(1, 0);
        chk("R8", "cleared after done at T1", timing, 32'h1);

        // Halt at step 2, then done and more cycles ignored: R9
        tick(0, 0); tick(0, 0);
        tick(0, 1);
        for (int i = 0; i < 5; i++) tick(1, 0);
        chk("R9", "frozen step", timing, 32'h1 << 2);

        // Reset with top start address: PC wraps on fetch (R1 R4)
        do_reset(12'hFFF);
        tick(0, 0); tick(0, 0);
        chk("R4", "pc wraps to zero", pc_q, 12'h000);
        tick(1, 0);
        chk("R8", "cleared after done at T2", timing, 32'h1);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule